// File: doc/BRIEF.md
# Capture-Mode Timer Channel

This block is a single timer channel that measures when external events happen. A free-running counter advances on a chosen count source. Selected edges on input A copy the counter into a first capture register and then into a second one, in that order. Input A and input B are used only as inputs.

A trigger sets the counter back to zero. A trigger can come from software, from a chosen edge on input A or input B, or from a match between the counter and a compare register. Software can also stop the counter after the second capture, or turn the count clock off at that point. The four asynchronous inputs (count clock, gate, A and B) each pass through a synchroniser before any edge is detected. A small word-addressed register port holds the mode word and the compare value, returns the counter, the captures and the sticky status, and sets the interrupt mask.

Register map (byte offsets; every access uses a whole word):

| Offset | Access | Contents |
|---|---|---|
| 0x00 | write | control: bit 0 enable, bit 1 disable, bit 2 software trigger |
| 0x04 | read/write | mode word (see R3, R5, R6, R8 to R11) |
| 0x10 | read | counter value |
| 0x14 | read | first capture |
| 0x18 | read | second capture |
| 0x1C | read/write | compare value |
| 0x20 | read | status (see R12) |
| 0x24 | write | set interrupt mask bits |
| 0x28 | write | clear interrupt mask bits |
| 0x2C | read | interrupt mask |

Top module: `capture_timer`

## Requirements
- R1: After reset, the following are all zero: counter, both captures, status, interrupt mask and mode word. The compare value is all ones, the count clock is off and irq_o is low.
- R2: A write to control offset 0x00 acts through three bits. Bit 0 turns the count clock on. Bit 1 turns it off, and bit 1 wins when both bits are set. Bit 2 is a software trigger that clears the counter. Status bit 16 shows whether the count clock is on.
- R3: Mode bit 0 selects the count source. With bit 0 at 0 the counter advances on every clock cycle while it is on. With bit 0 at 1 it advances on rising edges of the synchronised ext_clk_i. Mode bit 1 makes it count falling edges of ext_clk_i instead. With mode bit 2 set, counting happens only while the synchronised gate_i is high.
- R4: When the counter advances from all ones, it wraps to zero and sets status bit 0.
- R5: Mode bits [4:3] select the edge of input A that loads the first capture, coded 0 none, 1 rising, 2 falling, 3 both. The first capture loads only once after a trigger, and loads again only after the second capture has loaded or after another trigger. Each load sets status bit 5.
- R6: Mode bits [6:5] select the edge of input A that loads the second capture, with the same coding. The second capture loads only while the first capture has loaded and the second has not yet followed it. Each load sets status bit 6.
- R7: If either capture register loads again before software has read its previous value, status bit 1 (load overrun) is set.
- R8: With mode bit 7 set, loading the second capture freezes the counter until the next trigger. The count clock stays on during the freeze.
- R9: With mode bit 8 set, loading the second capture turns the count clock off, and status bit 16 reads 0.
- R10: Mode bits [10:9] select the external trigger edge, coded 0 none, 1 rising, 2 falling, 3 both. Mode bit 11 picks input A as the trigger source; when bit 11 is clear, input B is the source. An external trigger clears the counter and sets status bit 7, and edges on the input that is not selected do nothing.
- R11: Status bit 4 is set when the counter advances while it equals the compare value. With mode bit 12 set, that advance clears the counter instead of incrementing it.
- R12: Read data appears on rdata_o with rvalid_o one cycle after rd_en_i. Status bits [7:0] are sticky and are cleared when the status word is read. An event that occurs in the same cycle as that read stays set.
- R13: A write to 0x24 sets mask bits and a write to 0x28 clears them. irq_o is high while any status bit in [7:0] is set and its mask bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | Asynchronous external count source |
| gate_i | input | 1 | Asynchronous count gate |
| pin_a_i | input | 1 | Asynchronous capture and trigger input A |
| pin_b_i | input | 1 | Asynchronous trigger input B |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the channel with CNT_W set to 8 and keeps the default synchroniser depth of two. An 8-bit counter reaches its wrap after 256 external count pulses, so the overflow flag and the compare value at the top of the range can be checked within the run. Apart from one stretch that measures the system-clock count source, every count comes from an external pulse driven by the bench. As a result, the values in the counter and in both captures are exact and do not depend on synchroniser latency.

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_i,
  input  logic              gate_i,
  input  logic              pin_a_i,
  input  logic              pin_b_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  localparam int IN_N   = 4;
  localparam int MODE_W = 13;
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_MODE  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_CV    = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_RA    = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFS_RB    = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFS_RC    = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] OFS_IEN   = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] OFS_IDIS  = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] OFS_IMASK = ADDR_W'('h2C);

  // input synchronisers: index 0 ext clock, 1 gate, 2 pin A, 3 pin B
  logic [IN_N-1:0] raw_in, lvl, rise, fall;
  assign raw_in = {pin_b_i, pin_a_i, gate_i, ext_clk_i};

  for (genvar gi = 0; gi < IN_N; gi++) begin : g_sync
    logic [SYNC_N:0] pipe;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[SYNC_N-1:0], raw_in[gi]};
    assign lvl[gi]  = pipe[SYNC_N-1];
    assign rise[gi] = pipe[SYNC_N-1] & ~pipe[SYNC_N];
    assign fall[gi] = ~pipe[SYNC_N-1] & pipe[SYNC_N];
  end

  function automatic logic edge_hit(input logic [1:0] code, input logic r, input logic f);
    return (code[0] & r) | (code[1] & f);
  endfunction

  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cnt_q, ra_q, rb_q, rc_q;
  logic [7:0]        sts_q, imask_q, evt;
  logic              clk_on_q, frozen_q, ra_done_q, ra_unread_q, rb_unread_q;

  logic       src_ext, clk_inv, gate_en, stop_rb, dis_rb, trg_sel_a, rc_trg;
  logic [1:0] ra_edge, rb_edge, trg_edge;
  assign src_ext   = mode_q[0];
  assign clk_inv   = mode_q[1];
  assign gate_en   = mode_q[2];
  assign ra_edge   = mode_q[4:3];
  assign rb_edge   = mode_q[6:5];
  assign stop_rb   = mode_q[7];
  assign dis_rb    = mode_q[8];
  assign trg_edge  = mode_q[10:9];
  assign trg_sel_a = mode_q[11];
  assign rc_trg    = mode_q[12];

  logic wr_ctrl, wr_mode, wr_rc, wr_ien, wr_idis, rd_ra, rd_rb, rd_stat;
  assign wr_ctrl = wr_en_i && addr_i == OFS_CTRL;
  assign wr_mode = wr_en_i && addr_i == OFS_MODE;
  assign wr_rc   = wr_en_i && addr_i == OFS_RC;
  assign wr_ien  = wr_en_i && addr_i == OFS_IEN;
  assign wr_idis = wr_en_i && addr_i == OFS_IDIS;
  assign rd_ra   = rd_en_i && addr_i == OFS_RA;
  assign rd_rb   = rd_en_i && addr_i == OFS_RB;
  assign rd_stat = rd_en_i && addr_i == OFS_STAT;

  logic tick, count_en, rc_hit, sw_trg, ext_trg, trig, ovf, ra_ld, rb_ld, lovr;
  assign tick     = src_ext ? (clk_inv ? fall[0] : rise[0]) : 1'b1;
  assign count_en = clk_on_q && !frozen_q && tick && (!gate_en || lvl[1]);
  assign rc_hit   = count_en && cnt_q == rc_q;
  assign sw_trg   = wr_ctrl && wdata_i[2];
  assign ext_trg  = trg_sel_a ? edge_hit(trg_edge, rise[2], fall[2])
                              : edge_hit(trg_edge, rise[3], fall[3]);
  assign trig     = sw_trg || ext_trg || (rc_hit && rc_trg);
  assign ovf      = count_en && !trig && cnt_q == CNT_MAX;
  assign ra_ld    = edge_hit(ra_edge, rise[2], fall[2]) && !ra_done_q;
  assign rb_ld    = edge_hit(rb_edge, rise[2], fall[2]) && ra_done_q;
  assign lovr     = (ra_ld && ra_unread_q) || (rb_ld && rb_unread_q);
  assign evt      = {ext_trg, rb_ld, ra_ld, rc_hit, 2'b00, lovr, ovf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      rc_q    <= '1;
      imask_q <= '0;
    end else begin
      if (wr_mode) mode_q <= wdata_i[MODE_W-1:0];
      if (wr_rc)   rc_q   <= wdata_i[CNT_W-1:0];
      if (wr_ien)  imask_q <= imask_q | wdata_i[7:0];
      else if (wr_idis) imask_q <= imask_q & ~wdata_i[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      clk_on_q <= 1'b0;
      frozen_q <= 1'b0;
    end else begin
      if (trig)          cnt_q <= '0;
      else if (count_en) cnt_q <= cnt_q + 1'b1;
      if ((wr_ctrl && wdata_i[1]) || (rb_ld && dis_rb)) clk_on_q <= 1'b0;
      else if (wr_ctrl && wdata_i[0])                   clk_on_q <= 1'b1;
      if (trig)                  frozen_q <= 1'b0;
      else if (rb_ld && stop_rb) frozen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q        <= '0;
      rb_q        <= '0;
      ra_done_q   <= 1'b0;
      ra_unread_q <= 1'b0;
      rb_unread_q <= 1'b0;
    end else begin
      if (ra_ld) ra_q <= cnt_q;
      if (rb_ld) rb_q <= cnt_q;
      if (trig)       ra_done_q <= 1'b0;
      else if (ra_ld) ra_done_q <= 1'b1;
      else if (rb_ld) ra_done_q <= 1'b0;
      if (ra_ld)      ra_unread_q <= 1'b1;
      else if (rd_ra) ra_unread_q <= 1'b0;
      if (rb_ld)      rb_unread_q <= 1'b1;
      else if (rd_rb) rb_unread_q <= 1'b0;
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFS_MODE:  rd_mux = 32'(mode_q);
      OFS_CV:    rd_mux = 32'(cnt_q);
      OFS_RA:    rd_mux = 32'(ra_q);
      OFS_RB:    rd_mux = 32'(rb_q);
      OFS_RC:    rd_mux = 32'(rc_q);
      OFS_STAT:  rd_mux = {15'd0, clk_on_q, 8'd0, sts_q};
      OFS_IMASK: rd_mux = {24'd0, imask_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q    <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      sts_q    <= rd_stat ? evt : (sts_q | evt);
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  assign irq_o = |(sts_q & imask_q);

  logic unused_bits;
  assign unused_bits = ^{wdata_i[31:MODE_W], lvl[0], lvl[3:2], rise[1], fall[1]};

  a_r2_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata_i[1]) |=> !clk_on_q);
  a_r4_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !trig && cnt_q == CNT_MAX) |=> (cnt_q == '0 && sts_q[0]));
  a_r5_ra_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_done_q && !trig) |=> $stable(ra_q));
  a_r6_rb_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    rb_ld |=> !ra_done_q);
  a_r8_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !trig) |=> $stable(cnt_q));
  a_r11_rc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_hit && rc_trg) |=> (cnt_q == '0 && sts_q[4]));
  a_r12_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rvalid_o);
endmodule

// File: tb/test_capture_timer.sv
module test_capture_timer;
  localparam int ADDR_W = 8;
  localparam logic [31:0] ON = 32'h0001_0000;
  localparam int M_EXT = 1, M_INV = 2, M_GATE = 4, RA_RISE = 8, RA_FALL = 16, RA_BOTH = 24;
  localparam int RB_RISE = 32, RB_FALL = 64, RB_BOTH = 96, M_STOP = 128, M_DIS = 256;
  localparam int TRG_RISE = 512, TRG_A = 2048, M_RCTRG = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_clk = 1'b0, gate = 1'b0, pa = 1'b0, pb = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, irq;
  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  capture_timer #(.CNT_W(8), .SYNC_N(2), .ADDR_W(ADDR_W)) i_capture_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .gate_i(gate),
    .pin_a_i(pa), .pin_b_i(pb), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data: actual %h expected none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    settle();
  endtask

  task automatic set_a(input logic v); pa = v; settle(); endtask
  task automatic set_b(input logic v); pb = v; settle(); endtask
  task automatic trig(); wr(8'h00, 32'd4); settle(); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h20, 32'h0, "R1 status");
    rd(8'h10, 32'h0, "R1 counter");
    rd(8'h14, 32'h0, "R1 first capture");
    rd(8'h2C, 32'h0, "R1 mask");
    rd(8'h1C, 32'hFF, "R1 compare");
    chk(irq, 1'b0, "R1 irq");
    // R3 system clock source: 10 counted cycles
    wr(8'h04, 32'd0);
    wr(8'h00, 32'd4);
    wr(8'h00, 32'd1);
    repeat (9) @(negedge clk);
    wr(8'h00, 32'd2);
    rd(8'h10, 32'd10, "R3 system clock count");
    rd(8'h10, 32'd10, "R2 counter held when off");
    rd(8'h20, 32'h0, "R2 clock off status");
    wr(8'h00, 32'd3);
    rd(8'h20, 32'h0, "R2 disable wins");
    wr(8'h00, 32'd1);
    rd(8'h20, ON, "R2 enabled status");
    // R3 gate, invert, plain external
    wr(8'h04, M_EXT | M_GATE);
    trig();
    pulses(3);
    rd(8'h10, 32'd0, "R3 gate low blocks");
    gate = 1'b1; settle();
    pulses(2);
    rd(8'h10, 32'd2, "R3 gate high counts");
    wr(8'h04, M_EXT | M_INV);
    trig();
    ext_clk = 1'b1; settle();
    rd(8'h10, 32'd0, "R3 invert ignores rise");
    ext_clk = 1'b0; settle();
    rd(8'h10, 32'd1, "R3 invert counts fall");
    wr(8'h04, M_EXT);
    trig();
    pulses(5);
    rd(8'h10, 32'd5, "R3 external count");
    // R5 R6 R12 capture sequence
    wr(8'h04, M_EXT | RA_RISE | RB_FALL);
    trig();
    pulses(3);
    set_a(1'b1);
    rd(8'h14, 32'd3, "R5 first capture");
    rd(8'h20, ON | 32'h20, "R5 load flag");
    rd(8'h20, ON, "R12 cleared on read");
    pulses(2);
    set_a(1'b0);
    rd(8'h18, 32'd5, "R6 second capture");
    rd(8'h20, ON | 32'h40, "R6 load flag");
    rd(8'h14, 32'd3, "R6 first capture kept");
    // R7 overrun
    pulses(1);
    set_a(1'b1);
    pulses(1);
    set_a(1'b0);
    pulses(1);
    set_a(1'b1);
    rd(8'h20, ON | 32'h62, "R7 overrun flag");
    rd(8'h14, 32'd8, "R7 first capture reloaded");
    rd(8'h18, 32'd7, "R7 second capture");
    // R5 one load per trigger, re-armed by trigger
    wr(8'h04, M_EXT | RA_RISE);
    set_a(1'b0);
    trig();
    pulses(2);
    set_a(1'b1);
    rd(8'h14, 32'd2, "R5 loaded after trigger");
    set_a(1'b0);
    pulses(2);
    set_a(1'b1);
    rd(8'h14, 32'd2, "R5 no second load");
    rd(8'h20, ON | 32'h20, "R5 single load no overrun");
    trig();
    set_a(1'b0);
    pulses(1);
    set_a(1'b1);
    rd(8'h14, 32'd1, "R5 rearmed by trigger");
    rd(8'h20, ON | 32'h20, "R5 status after rearm");
    // R5 R6 both-edge coding
    wr(8'h04, M_EXT | RA_BOTH | RB_BOTH);
    trig();
    pulses(1);
    set_a(1'b0);
    pulses(1);
    set_a(1'b1);
    rd(8'h14, 32'd1, "R5 both edges first");
    rd(8'h18, 32'd2, "R6 both edges second");
    rd(8'h20, ON | 32'h60, "R6 both edges flags");
    // R8 stop on second load
    wr(8'h04, M_EXT | RA_RISE | RB_FALL | M_STOP);
    set_a(1'b0);
    trig();
    pulses(2);
    set_a(1'b1);
    pulses(1);
    set_a(1'b0);
    pulses(2);
    rd(8'h10, 32'd3, "R8 counter frozen");
    rd(8'h20, ON | 32'h60, "R8 clock stays on");
    trig();
    pulses(1);
    rd(8'h10, 32'd1, "R8 trigger restarts");
    rd(8'h14, 32'd2, "R8 first capture");
    rd(8'h18, 32'd3, "R8 second capture");
    // R9 disable on second load
    wr(8'h04, M_EXT | RA_RISE | RB_FALL | M_DIS);
    trig();
    pulses(1);
    set_a(1'b1);
    set_a(1'b0);
    rd(8'h20, 32'h60, "R9 clock turned off");
    pulses(2);
    rd(8'h10, 32'd1, "R9 no counting");
    wr(8'h00, 32'd1);
    rd(8'h14, 32'd1, "R9 first capture");
    rd(8'h18, 32'd1, "R9 second capture");
    // R10 external trigger
    wr(8'h04, M_EXT | TRG_RISE);
    trig();
    pulses(3);
    set_b(1'b1);
    rd(8'h10, 32'd0, "R10 B rise clears");
    rd(8'h20, ON | 32'h80, "R10 trigger flag");
    set_b(1'b0);
    pulses(2);
    rd(8'h10, 32'd2, "R10 fall ignored");
    wr(8'h04, M_EXT | TRG_RISE | TRG_A);
    set_b(1'b1);
    rd(8'h10, 32'd2, "R10 unselected B ignored");
    rd(8'h20, ON, "R10 no flag from B");
    // R11 compare
    wr(8'h1C, 32'd3);
    wr(8'h04, M_EXT | M_RCTRG);
    trig();
    pulses(5);
    rd(8'h10, 32'd1, "R11 compare restarts");
    rd(8'h20, ON | 32'h10, "R11 compare flag");
    wr(8'h04, M_EXT);
    trig();
    pulses(5);
    rd(8'h10, 32'd5, "R11 compare no restart");
    rd(8'h20, ON | 32'h10, "R11 compare flag only");
    // R4 wrap
    trig();
    pulses(255);
    rd(8'h10, 32'd255, "R4 top value");
    rd(8'h20, ON | 32'h10, "R4 no wrap yet");
    pulses(1);
    rd(8'h10, 32'd0, "R4 wrapped");
    rd(8'h20, ON | 32'h01, "R4 wrap flag");
    // R13 interrupt
    wr(8'h24, 32'h20);
    rd(8'h2C, 32'h20, "R13 mask set");
    chk(irq, 1'b0, "R13 irq idle");
    wr(8'h04, M_EXT | RA_RISE);
    set_a(1'b0);
    trig();
    set_a(1'b1);
    chk(irq, 1'b1, "R13 irq raised");
    rd(8'h20, ON | 32'h20, "R13 status");
    chk(irq, 1'b0, "R13 irq cleared by read");
    wr(8'h28, 32'h20);
    rd(8'h2C, 32'h0, "R13 mask cleared");
    settle();
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule